// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock timing for an I2C master. It runs from the system oscillator clock. An 8-bit reload value N sets the bit rate. An internal enable fires on every second oscillator cycle, and a down counter advances on that enable. Each time the counter runs out, the block reloads it from N, inverts the SCL drive level and pulses a half-period tick for one oscillator cycle. The counter therefore reloads twice per SCL period, and the resulting SCL frequency is Fosc / (4 × (N + 1)). For example, with an 8 MHz oscillator, N = 0x13 gives 100 kHz, N = 0x0B about 166 kHz and N = 0x04 400 kHz.

Counting starts when software writes the transmit buffer, but only while the mode field selects master operation. Counting stops when the byte operation reports completion, or when the mode leaves master operation. SCL then holds whatever level it had. While the block releases SCL high but the sensed line still reads low, the high half-phase does not start counting. This lets a slave stretch the clock. A reload value of 0, 1 or 2 cannot give valid bus timing, so the block stores 3 instead and raises a sticky error flag.

Top module: `i2c_scl_brg`

## Requirements
- R1: After reset, scl_drive is 1 (released), half_tick is 0, rate_err is 0, the reload value is 0x13, and no counting takes place until a start.
- R2: After an accepted start, the first SCL drive change comes 2(N+1) oscillator cycles after the start cycle. Each later change follows the previous one after 2(N+1) cycles, so one SCL period is 4(N+1) cycles.
- R3: half_tick is high for exactly one cycle, in the same cycle as each change of scl_drive, and at no other time.
- R4: A reload write of 0x00, 0x01 or 0x02 stores 3 and sets rate_err. rate_err stays set through later valid writes and clears only on reset.
- R5: buf_wr starts counting only when mode_sel equals 4'b1000 (master). With any other mode value, buf_wr is ignored.
- R6: op_done stops counting. scl_drive keeps its last level and half_tick stays low until the next start. If op_done and buf_wr arrive in the same cycle, op_done wins.
- R7: Clock stretching. While scl_drive is 1 and scl_in reads 0, the high half-phase does not advance. If the line rises h cycles after the drive change, with h even, the high half-phase lasts 2N + h + 2 cycles.
- R8: If mode_sel leaves 4'b1000 while counting, counting stops as for op_done.
- R9: A reload write during counting leaves the half-phase in progress unchanged and takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Operating mode; 4'b1000 selects master |
| rate_wr | input | 1 | Write strobe for the reload value |
| rate_wdata | input | 8 | Reload value N |
| buf_wr | input | 1 | Transmit buffer write; starts counting |
| op_done | input | 1 | Byte operation finished; stops counting |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive | output | 1 | SCL drive level (1 = released high) |
| half_tick | output | 1 | One-cycle pulse at each half-period boundary |
| rate_err | output | 1 | Sticky flag for a rejected reload value |

## Verification
The bench measures the interval between ticks across a range of reload values, including the clamped ones. A design that reloaded only once per period, or stepped on every oscillator cycle, would show intervals of double or half the expected length. Clock stretching is checked for the exact extended length of the high phase, which catches a design that ignores the sensed line or pauses without reloading. It also checks that op_done beats a simultaneous buf_wr, that SCL stays frozen after a stop or a mode change, and that a mid-phase rate write does not disturb the current half-phase.

// File: rtl/i2c_brg_pkg.sv
`timescale 1ns/1ps
package i2c_brg_pkg;
  localparam int unsigned BRG_RATE_W = 8;
  localparam int unsigned BRG_MODE_W = 4;
  localparam logic [BRG_RATE_W-1:0] BRG_RATE_RST = 8'h13;
  localparam logic [BRG_RATE_W-1:0] BRG_RATE_MIN = 8'h03;
  localparam logic [BRG_MODE_W-1:0] BRG_MODE_MASTER = 4'b1000;

  typedef struct packed {
    logic run;
    logic scl;
    logic tick;
  } brg_ctl_t;
endpackage

// File: rtl/i2c_brg_rst_sync.sv
`timescale 1ns/1ps
module i2c_brg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_brg_rate_reg.sv
`timescale 1ns/1ps
module i2c_brg_rate_reg #(
  parameter int unsigned        W       = 8,
  parameter logic [W-1:0]       RST_VAL = 8'h13,
  parameter logic [W-1:0]       MIN_VAL = 8'h03
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rate_q,
  output logic         err_q
);
  logic [W-1:0] rate_n;
  logic         err_n;
  logic         too_small;

  assign too_small = (wr_data < MIN_VAL);

  always_comb begin
    rate_n = rate_q;
    err_n  = err_q;
    if (wr_en) begin
      rate_n = too_small ? MIN_VAL : wr_data;
      err_n  = err_q | too_small;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RST_VAL;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      rate_q <= rate_n;
      err_q  <= err_n;
    end
  end

  // R4: the stored value never drops below the floor
  p_rate_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q >= MIN_VAL);
  // R4: the error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R4: a rejected write raises the flag
  p_err_on_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data < MIN_VAL) |=> (err_q && rate_q == MIN_VAL));
endmodule

// File: rtl/i2c_brg_prescale.sv
`timescale 1ns/1ps
module i2c_brg_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic half_en
);
  logic ph_q;
  logic ph_n;

  always_comb begin
    if (restart)  ph_n = 1'b0;
    else if (run) ph_n = ~ph_q;
    else          ph_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_n;
  end

  assign half_en = run & ph_q & ~restart;

  // R2: the counting enable never fires on two cycles in a row
  p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_en |=> !half_en);
endmodule

// File: rtl/i2c_brg_down_cnt.sv
`timescale 1ns/1ps
module i2c_brg_down_cnt
  import i2c_brg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         half_en,
  input  logic [W-1:0] reload,
  input  logic         scl_in,
  output logic         scl_drive,
  output logic         half_tick,
  output logic         running
);
  brg_ctl_t     ctl_q, ctl_n;
  logic [W-1:0] cnt_q, cnt_n;
  logic         stretched;
  logic         cnt_upd;

  assign stretched = ctl_q.scl & ~scl_in;
  assign cnt_upd   = stop | start | (ctl_q.run & half_en);

  always_comb begin
    ctl_n      = ctl_q;
    ctl_n.tick = 1'b0;
    cnt_n      = cnt_q;
    if (stop) begin
      ctl_n.run = 1'b0;
    end else if (start) begin
      ctl_n.run = 1'b1;
      cnt_n     = reload;
    end else if (ctl_q.run && half_en) begin
      if (stretched) begin
        cnt_n = reload;
      end else if (cnt_q == '0) begin
        ctl_n.scl  = ~ctl_q.scl;
        ctl_n.tick = 1'b1;
        cnt_n      = reload;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{run: 1'b0, scl: 1'b1, tick: 1'b0};
    end else begin
      ctl_q <= ctl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_n;
  end

  assign scl_drive = ctl_q.scl;
  assign half_tick = ctl_q.tick;
  assign running   = ctl_q.run;

  // R3: every drive change is marked by the tick
  p_tick_marks_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive != $past(scl_drive)) |-> half_tick);
  // R3: the tick lasts one cycle
  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
  // R6: no activity while stopped
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(scl_drive) && !half_tick));
  // R7: a held-low line blocks the edge
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && half_en && scl_drive && !scl_in && !stop && !start) |=> !half_tick);
endmodule

// File: rtl/i2c_scl_brg.sv
`timescale 1ns/1ps
module i2c_scl_brg
  import i2c_brg_pkg::*;
#(
  parameter int unsigned           RATE_W      = BRG_RATE_W,
  parameter int unsigned           MODE_W      = BRG_MODE_W,
  parameter logic [RATE_W-1:0]     RATE_RST    = BRG_RATE_RST,
  parameter logic [RATE_W-1:0]     RATE_MIN    = BRG_RATE_MIN,
  parameter logic [MODE_W-1:0]     MODE_MASTER = BRG_MODE_MASTER,
  parameter int unsigned           SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  input  logic              buf_wr,
  input  logic              op_done,
  input  logic              scl_in,
  output logic              scl_drive,
  output logic              half_tick,
  output logic              rate_err
);
  logic              rst_i_n;
  logic [RATE_W-1:0] rate_q;
  logic              is_master;
  logic              go;
  logic              halt;
  logic              half_en;
  logic              running;

  i2c_brg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  i2c_brg_rate_reg #(.W(RATE_W), .RST_VAL(RATE_RST), .MIN_VAL(RATE_MIN)) u_rate (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (rate_wr),
    .wr_data (rate_wdata),
    .rate_q  (rate_q),
    .err_q   (rate_err)
  );

  assign is_master = (mode_sel == MODE_MASTER);
  assign halt      = op_done | (running & ~is_master);
  assign go        = buf_wr & is_master & ~op_done;

  i2c_brg_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (running),
    .restart (go),
    .half_en (half_en)
  );

  i2c_brg_down_cnt #(.W(RATE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (go),
    .stop      (halt),
    .half_en   (half_en),
    .reload    (rate_q),
    .scl_in    (scl_in),
    .scl_drive (scl_drive),
    .half_tick (half_tick),
    .running   (running)
  );

  // R5: a buffer write outside master mode does not start counting
  p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (buf_wr && !is_master && !running) |=> !running);
  // R6: op_done always stops counting, even with a simultaneous start
  p_done_wins_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    op_done |=> !running);
  // R8: leaving master mode stops counting
  p_mode_leave_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (running && !is_master) |=> !running);
endmodule

// File: tb/test_i2c_scl_brg.sv
`timescale 1ns/1ps
module test_i2c_scl_brg;
  localparam int NV = 7;
  localparam int VEC_N    [NV] = '{8'h13, 8'h04, 8'h0B, 8'h03, 8'h00, 8'h01, 8'hFF};
  localparam int VEC_HALF [NV] = '{40, 10, 24, 8, 8, 8, 512};
  localparam logic [3:0] MASTER = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode_sel;
  logic       rate_wr, buf_wr, op_done, slave_hold;
  logic [7:0] rate_wdata;
  logic       scl_in, scl_drive, half_tick, rate_err;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  assign scl_in = scl_drive & ~slave_hold;

  i2c_scl_brg i_i2c_scl_brg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .buf_wr(buf_wr), .op_done(op_done),
    .scl_in(scl_in), .scl_drive(scl_drive), .half_tick(half_tick),
    .rate_err(rate_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_rate(input int v);
    rate_wr = 1'b1; rate_wdata = v[7:0];
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic do_start();
    buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic do_stop();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  // counts negedges until a tick is seen; -1 on timeout
  task automatic wait_pulse(output int n);
    n = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      n++;
      if (half_tick) return;
    end
    n = -1;
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (half_tick) p++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, p, lvl;
    mode_sel = MASTER; rate_wr = 0; rate_wdata = 0; buf_wr = 0;
    op_done = 0; slave_hold = 0; rst_n = 0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1 scl_drive", scl_drive, 1);
    chk("R1 half_tick", half_tick, 0);
    chk("R1 rate_err", rate_err, 0);
    count_pulses(50, p);
    chk("R1 idle no ticks", p, 0);
    do_start();
    wait_pulse(n);
    chk("R1 default rate 0x13 half period", n, 40);
    chk("R2 first edge drives low", scl_drive, 0);

    // R2/R3: vector walk over rates (0x00 and 0x01 clamp to 3, R4)
    for (int i = 0; i < NV; i++) begin
      do_stop();
      wr_rate(VEC_N[i]);
      lvl = scl_drive;
      do_start();
      wait_pulse(n);
      chk("R2 first half period", n, VEC_HALF[i]);
      chk("R3 edge on tick", scl_drive, 1 - lvl);
      @(negedge clk);
      chk("R3 tick one cycle", half_tick, 0);
      wait_pulse(n);
      chk("R2 next half period", n, VEC_HALF[i] - 1);
      chk("R3 edge back", scl_drive, lvl);
    end

    // R4: clamp and sticky error
    do_reset();
    wr_rate(8'h05);
    chk("R4 valid write no error", rate_err, 0);
    wr_rate(8'h02);
    chk("R4 invalid write sets error", rate_err, 1);
    do_start();
    wait_pulse(n);
    chk("R4 0x02 clamped to 3", n, 8);
    wr_rate(8'h13);
    chk("R4 error sticky", rate_err, 1);

    // R9: mid-run rate change applies from next reload
    do_stop();
    wr_rate(8'h04);
    do_start();
    wait_pulse(n);
    wr_rate(8'h09);
    wait_pulse(n);
    chk("R9 current phase unchanged", n, 9);
    wait_pulse(n);
    chk("R9 new rate after reload", n, 20);

    // R6: stop freezes level
    do_stop();
    lvl = scl_drive;
    count_pulses(60, p);
    chk("R6 no ticks after done", p, 0);
    chk("R6 level held", scl_drive, lvl);
    // R6: op_done wins over same-cycle buf_wr
    op_done = 1'b1; buf_wr = 1'b1;
    @(negedge clk);
    op_done = 1'b0; buf_wr = 1'b0;
    count_pulses(60, p);
    chk("R6 done beats start", p, 0);

    // R5: start ignored outside master mode
    mode_sel = 4'b0000;
    do_start();
    count_pulses(60, p);
    chk("R5 start ignored in other mode", p, 0);
    mode_sel = MASTER;

    // R8: leaving master mode while running stops counting
    do_start();
    wait_pulse(n);
    chk("R8 runs in master mode", n, 20);
    mode_sel = 4'b0011;
    lvl = scl_drive;
    count_pulses(60, p);
    chk("R8 no ticks after mode leave", p, 0);
    chk("R8 level held", scl_drive, lvl);
    mode_sel = MASTER;

    // R7: clock stretching, slave holds line low 10 cycles into high phase
    do_reset();
    wr_rate(8'h05);
    do_start();
    wait_pulse(n);
    chk("R7 low edge before stretch", n, 12);
    slave_hold = 1'b1;
    wait_pulse(n);
    chk("R7 low phase unaffected", n, 12);
    chk("R7 drive released", scl_drive, 1);
    count_pulses(10, p);
    slave_hold = 1'b0;
    chk("R7 no edge while held", p, 0);
    wait_pulse(n);
    chk("R7 stretched high phase", n + 10, 22);
    wait_pulse(n);
    chk("R7 normal after release", n, 12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule